// File: doc/BRIEF.md
# Montgomery Modulus Coefficient Calculator

This block derives the constant that Montgomery reduction needs for a given odd modulus: the value c with n·c ≡ −1 (mod 2^k), where k is 32 bits times the number of active words. The modulus sits in an external word-addressed memory. After a start pulse the block fetches it word by word through a synchronous read port, refines the coefficient one bit per clock, and streams the result words into a second memory through an address, data and write-enable interface.

The caller sets the word count, pulses start while ready is high, and waits for ready to return. Up to 16 words of 32 bits (512-bit operands) are supported with the default parameters. Only odd moduli give a meaningful result; an even modulus is not flagged.

Top module: `ncf_montcoef`

## Requirements
- R1: During and right after synchronous reset, `ready` is 1 and `coef_we` is 0.
- R2: `word_cnt` holds the number of words minus one and is sampled on an accepted start; k = 32·(word_cnt+1). Exactly word_cnt+1 coefficient words are written, and modulus words above index word_cnt have no effect on the result.
- R3: Coefficient words are written least significant first, one word per cycle with `coef_we` high, at addresses 0, 1, 2, ... rising by one per write.
- R4: The modulus is read through `mod_addr`, with `mod_data` holding the word for an address on the cycle after that address is driven; address 0 holds the least significant word.
- R5: The written coefficient equals the result of: r = 1, b = 1, nn = −n mod 2^k; for i = 1 to k−1, b = 2b, t = r·nn mod 2^k, and r = r + b when bit i of t is 1. For odd n this gives (n·r + 1) mod 2^k = 0.
- R6: A start pulse while `ready` is 1 drops `ready` on the next cycle; `ready` stays 0 until every word is written, `coef_we` is never 1 while `ready` is 1, and `ready` returns to 1 after the last write.
- R7: A start pulse while `ready` is 0 is ignored: the word count in use does not change and the run is not restarted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin |
| word_cnt | input | 4 | Active words minus one |
| ready | output | 1 | High when idle and the last result is complete |
| mod_addr | output | 4 | Modulus memory read address |
| mod_data | input | 32 | Modulus word, one cycle after its address |
| coef_addr | output | 4 | Coefficient memory write address |
| coef_data | output | 32 | Coefficient word to write |
| coef_we | output | 1 | Write strobe, one word per cycle |

## Verification
On every cycle the assertions hold the protocol: read and write addresses stay within the sampled word count, writes advance by one address per cycle, no write happens while ready is high, ready drops after an accepted start, and a start during a run leaves the word count untouched. Whether the coefficient is arithmetically correct can only be seen in the bench's scenarios, which compare every result against an independent model of the refinement procedure and against the inverse identity for random 384- and 512-bit moduli, the single-word case, a modulus of one, and stale memory words above the active count.

// File: rtl/ncf_pkg.sv
package ncf_pkg;
  localparam int NCF_WORD_W    = 32;
  localparam int NCF_ADDR_W    = 4;
  localparam int NCF_MAX_WORDS = 1 << NCF_ADDR_W;
  localparam int NCF_MAX_BITS  = NCF_WORD_W * NCF_MAX_WORDS;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_CALC,
    ST_STORE
  } ncf_state_e;
endpackage

// File: rtl/ncf_loader.sv
module ncf_loader #(
  parameter int WW = ncf_pkg::NCF_WORD_W,
  parameter int AW = ncf_pkg::NCF_ADDR_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      go,
  input  logic [AW-1:0]             last_word,
  output logic [AW-1:0]             rd_addr,
  input  logic [WW-1:0]             rd_data,
  output logic [WW*(1<<AW)-1:0]     n_val,
  output logic                      done
);
  localparam int MW = WW * (1 << AW);

  logic          issuing_q;
  logic [AW-1:0] addr_q;
  logic          pend_q;
  logic [AW-1:0] pend_idx_q;
  logic [MW-1:0] n_q;
  logic          done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      issuing_q  <= 1'b0;
      addr_q     <= '0;
      pend_q     <= 1'b0;
      pend_idx_q <= '0;
      n_q        <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q     <= 1'b0;
      pend_q     <= issuing_q;
      pend_idx_q <= addr_q;
      if (go) begin
        issuing_q <= 1'b1;
        addr_q    <= '0;
        n_q       <= '0;
      end else if (issuing_q) begin
        if (addr_q == last_word) issuing_q <= 1'b0;
        else                     addr_q    <= addr_q + 1'b1;
      end
      if (pend_q) begin
        n_q[int'(pend_idx_q)*WW +: WW] <= rd_data;
        if (pend_idx_q == last_word) done_q <= 1'b1;
      end
    end
  end

  assign rd_addr = addr_q;
  assign n_val   = n_q;
  assign done    = done_q;

  p_rd_in_range_r2: assert property (@(posedge clk) disable iff (rst)
    issuing_q |-> addr_q <= last_word);
  p_capture_order_r4: assert property (@(posedge clk) disable iff (rst)
    pend_q |-> pend_idx_q == $past(addr_q));
endmodule

// File: rtl/ncf_refine.sv
module ncf_refine #(
  parameter int WW = ncf_pkg::NCF_WORD_W,
  parameter int AW = ncf_pkg::NCF_ADDR_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          go,
  input  logic [WW*(1<<AW)-1:0]         n_val,
  input  logic [AW+$clog2(WW)-1:0]      last_bit,
  output logic [WW*(1<<AW)-1:0]         r_val,
  output logic                          done
);
  localparam int MW = WW * (1 << AW);
  localparam int BW = AW + $clog2(WW);

  logic [MW-1:0] nn_q;
  logic [MW-1:0] acc_q;
  logic [MW-1:0] r_q;
  logic [BW-1:0] step_q;
  logic          busy_q;
  logic          done_q;
  logic [MW-1:0] nn_c;
  logic [MW:0]   sum_c;

  // acc_q holds the pending product shifted down by the current step,
  // so bit 0 is always the bit under test.
  assign nn_c  = ~n_val + MW'(1);
  assign sum_c = {1'b0, acc_q} + {1'b0, (acc_q[0] ? nn_q : {MW{1'b0}})};

  always_ff @(posedge clk) begin
    if (rst) begin
      nn_q   <= '0;
      acc_q  <= '0;
      r_q    <= '0;
      step_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go) begin
        nn_q   <= nn_c;
        acc_q  <= nn_c >> 1;
        r_q    <= MW'(1);
        step_q <= BW'(1);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        r_q[step_q] <= acc_q[0];
        acc_q       <= sum_c[MW:1];
        if (step_q == last_bit) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          step_q <= step_q + 1'b1;
        end
      end
    end
  end

  assign r_val = r_q;
  assign done  = done_q;

  p_step_bound_r5: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (step_q != '0) && (step_q <= last_bit));
  p_lsb_set_r5: assert property (@(posedge clk) disable iff (rst)
    done_q |-> r_q[0]);
endmodule

// File: rtl/ncf_writer.sv
module ncf_writer #(
  parameter int WW = ncf_pkg::NCF_WORD_W,
  parameter int AW = ncf_pkg::NCF_ADDR_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      go,
  input  logic [WW*(1<<AW)-1:0]     r_val,
  input  logic [AW-1:0]             last_word,
  output logic [AW-1:0]             wr_addr,
  output logic [WW-1:0]             wr_data,
  output logic                      wr_en,
  output logic                      done
);
  localparam int MW = WW * (1 << AW);

  logic [MW-1:0] sh_q;
  logic [AW-1:0] idx_q;
  logic          busy_q;
  logic [AW-1:0] wr_addr_q;
  logic [WW-1:0] wr_data_q;
  logic          wr_en_q;
  logic          done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q      <= '0;
      idx_q     <= '0;
      busy_q    <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
      wr_en_q   <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      wr_en_q <= 1'b0;
      done_q  <= 1'b0;
      if (go) begin
        sh_q   <= r_val;
        idx_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        wr_en_q   <= 1'b1;
        wr_addr_q <= idx_q;
        wr_data_q <= sh_q[WW-1:0];
        sh_q      <= sh_q >> WW;
        if (idx_q == last_word) busy_q <= 1'b0;
        else                    idx_q  <= idx_q + 1'b1;
      end
      if (wr_en_q && (wr_addr_q == last_word)) done_q <= 1'b1;
    end
  end

  assign wr_addr = wr_addr_q;
  assign wr_data = wr_data_q;
  assign wr_en   = wr_en_q;
  assign done    = done_q;

  p_wr_in_range_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en_q |-> wr_addr_q <= last_word);
  p_wr_ascend_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en_q && $past(wr_en_q)) |-> wr_addr_q == $past(wr_addr_q) + 1'b1);
  p_wr_first_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en_q && !$past(wr_en_q)) |-> wr_addr_q == '0);
endmodule

// File: rtl/ncf_montcoef.sv
module ncf_montcoef #(
  parameter int WW = ncf_pkg::NCF_WORD_W,
  parameter int AW = ncf_pkg::NCF_ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] word_cnt,
  output logic          ready,
  output logic [AW-1:0] mod_addr,
  input  logic [WW-1:0] mod_data,
  output logic [AW-1:0] coef_addr,
  output logic [WW-1:0] coef_data,
  output logic          coef_we
);
  import ncf_pkg::*;
  localparam int MW = WW * (1 << AW);
  localparam int LW = $clog2(WW);

  ncf_state_e    st_q;
  logic          ready_q;
  logic [AW-1:0] nw_q;
  logic          ld_go_q, calc_go_q, wr_go_q;
  logic          ld_done, calc_done, wr_done;
  logic [MW-1:0] n_val, r_val;
  logic [AW+LW-1:0] last_bit;

  assign last_bit = {nw_q, {LW{1'b1}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      ready_q   <= 1'b1;
      nw_q      <= '0;
      ld_go_q   <= 1'b0;
      calc_go_q <= 1'b0;
      wr_go_q   <= 1'b0;
    end else begin
      ld_go_q   <= 1'b0;
      calc_go_q <= 1'b0;
      wr_go_q   <= 1'b0;
      case (st_q)
        ST_IDLE: if (start) begin
          nw_q    <= word_cnt;
          ready_q <= 1'b0;
          ld_go_q <= 1'b1;
          st_q    <= ST_LOAD;
        end
        ST_LOAD: if (ld_done) begin
          calc_go_q <= 1'b1;
          st_q      <= ST_CALC;
        end
        ST_CALC: if (calc_done) begin
          wr_go_q <= 1'b1;
          st_q    <= ST_STORE;
        end
        ST_STORE: if (wr_done) begin
          ready_q <= 1'b1;
          st_q    <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  ncf_loader #(.WW(WW), .AW(AW)) u_loader (
    .clk(clk), .rst(rst), .go(ld_go_q), .last_word(nw_q),
    .rd_addr(mod_addr), .rd_data(mod_data), .n_val(n_val), .done(ld_done)
  );

  ncf_refine #(.WW(WW), .AW(AW)) u_refine (
    .clk(clk), .rst(rst), .go(calc_go_q), .n_val(n_val),
    .last_bit(last_bit), .r_val(r_val), .done(calc_done)
  );

  ncf_writer #(.WW(WW), .AW(AW)) u_writer (
    .clk(clk), .rst(rst), .go(wr_go_q), .r_val(r_val), .last_word(nw_q),
    .wr_addr(coef_addr), .wr_data(coef_data), .wr_en(coef_we), .done(wr_done)
  );

  assign ready = ready_q;

  p_ready_drop_r6: assert property (@(posedge clk) disable iff (rst)
    (ready && start) |=> !ready);
  p_no_we_idle_r6: assert property (@(posedge clk) disable iff (rst)
    coef_we |-> !ready);
  p_busy_start_r7: assert property (@(posedge clk) disable iff (rst)
    (!ready && start) |=> nw_q == $past(nw_q));
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> ready && !coef_we);
endmodule

// File: tb/test_ncf_montcoef.sv
module test_ncf_montcoef;
  import ncf_pkg::*;
  localparam int WW = NCF_WORD_W;
  localparam int AW = NCF_ADDR_W;
  localparam int NW = NCF_MAX_WORDS;
  localparam int MB = NCF_MAX_BITS;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] word_cnt = '0;
  logic          ready;
  logic [AW-1:0] mod_addr;
  logic [WW-1:0] mod_data;
  logic [AW-1:0] coef_addr;
  logic [WW-1:0] coef_data;
  logic          coef_we;

  always #4 clk = ~clk;

  ncf_montcoef i_ncf_montcoef (
    .clk(clk), .rst(rst), .start(start), .word_cnt(word_cnt), .ready(ready),
    .mod_addr(mod_addr), .mod_data(mod_data),
    .coef_addr(coef_addr), .coef_data(coef_data), .coef_we(coef_we)
  );

  int n_run = 0;
  int n_fail = 0;
  logic [WW-1:0] mmem [0:NW-1];
  logic [WW-1:0] cmem [0:NW-1];
  int wr_total = 0;
  int addr_log [0:63];

  // Memory models: synchronous read port, write port with strobe.
  always @(posedge clk) begin
    mod_data <= mmem[mod_addr];
    if (coef_we) begin
      cmem[coef_addr] <= coef_data;
      addr_log[wr_total % 64] <= int'(coef_addr);
      wr_total <= wr_total + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [MB-1:0] act, input logic [MB-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [MB-1:0] kmask(input int k);
    return {MB{1'b1}} >> (MB - k);
  endfunction

  function automatic logic [MB-1:0] model_coef(input logic [MB-1:0] n, input int k);
    logic [MB-1:0] m, r, b, nn, t;
    m  = kmask(k);
    r  = 1;
    b  = 1;
    nn = (~n + 1'b1) & m;
    for (int i = 1; i < k; i++) begin
      b = b << 1;
      t = (r * nn) & m;
      if (t[i]) r = (r + b) & m;
    end
    return r;
  endfunction

  task automatic load_mod(input logic [MB-1:0] n);
    for (int w = 0; w < NW; w++) mmem[w] = n[w*WW +: WW];
  endtask

  task automatic wait_ready(input string req);
    int c;
    c = 0;
    while (!ready && c < 5000) begin
      @(negedge clk);
      c++;
    end
    check(ready, req, "ready return", MB'(ready), MB'(1));
  endtask

  task automatic gather(input int cnt, output logic [MB-1:0] got);
    got = '0;
    for (int w = 0; w <= cnt; w++) got[w*WW +: WW] = cmem[w];
  endtask

  task automatic check_writes(input int base, input int cnt);
    bit order_ok;
    check(wr_total - base == cnt + 1, "R2", "write count",
          MB'(wr_total - base), MB'(cnt + 1));
    order_ok = 1'b1;
    for (int j = 0; j <= cnt; j++)
      if (addr_log[(base + j) % 64] != j) order_ok = 1'b0;
    check(order_ok, "R3", "write address order", MB'(order_ok), MB'(1));
  endtask

  task automatic check_result(input logic [MB-1:0] n, input int cnt,
                              input logic [MB-1:0] got, input string tag);
    int k;
    logic [MB-1:0] nm, exp, prod;
    k    = WW * (cnt + 1);
    nm   = n & kmask(k);
    exp  = model_coef(nm, k);
    prod = (nm * got + 1'b1) & kmask(k);
    check(got == exp, "R5/R4", {tag, " coefficient"}, got, exp);
    check(prod == '0, "R5", {tag, " inverse identity"}, prod, '0);
  endtask

  task automatic run_case(input logic [MB-1:0] n, input int cnt, input string tag);
    int base;
    logic [MB-1:0] got;
    load_mod(n);
    base = wr_total;
    @(negedge clk);
    word_cnt = AW'(cnt);
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(!ready, "R6", {tag, " ready drops"}, MB'(ready), MB'(0));
    wait_ready("R6");
    gather(cnt, got);
    check_writes(base, cnt);
    check_result(n, cnt, got, tag);
  endtask

  function automatic logic [MB-1:0] rand_odd();
    logic [MB-1:0] v;
    for (int w = 0; w < NW; w++) v[w*WW +: WW] = $urandom;
    v[0] = 1'b1;
    return v;
  endfunction

  task automatic t_reset();
    check(ready == 1'b1, "R1", "ready after reset", MB'(ready), MB'(1));
    check(coef_we == 1'b0, "R1", "coef_we after reset", MB'(coef_we), MB'(0));
  endtask

  task automatic t_384();
    run_case(rand_odd(), 11, "384-bit A");
    run_case(rand_odd(), 11, "384-bit B");
  endtask

  task automatic t_512();
    run_case(rand_odd(), 15, "512-bit");
  endtask

  task automatic t_single_word();
    run_case(rand_odd(), 0, "32-bit");
  endtask

  task automatic t_one_with_stale();
    // Modulus 1 in the low four words, junk above: R2 says junk is ignored,
    // and R5 gives an all-ones coefficient of 128 bits.
    logic [MB-1:0] n;
    logic [MB-1:0] got;
    int base;
    n = rand_odd();
    n[4*WW-1:0] = '0;
    n[0] = 1'b1;
    load_mod(n);
    base = wr_total;
    @(negedge clk);
    word_cnt = 4'd3;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_ready("R6");
    gather(3, got);
    check_writes(base, 3);
    check(got == kmask(128), "R2", "stale high words ignored", got, kmask(128));
  endtask

  task automatic t_start_busy();
    logic [MB-1:0] n;
    logic [MB-1:0] got;
    int base;
    n = rand_odd();
    load_mod(n);
    base = wr_total;
    @(negedge clk);
    word_cnt = 4'd11;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (60) @(negedge clk);
    word_cnt = 4'd2;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(!ready, "R7", "ready stays low on busy start", MB'(ready), MB'(0));
    wait_ready("R7");
    gather(11, got);
    check(wr_total - base == 12, "R7", "word count unchanged",
          MB'(wr_total - base), MB'(12));
    check_result(n, 11, got, "R7 busy-start");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int w = 0; w < NW; w++) mmem[w] = '0;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_384();
    t_512();
    t_single_word();
    t_one_with_stale();
    t_start_busy();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule